// File: doc/BRIEF.md
# Base-Offset Address Generator With Writeback

This block forms the memory address for one load or store. It takes a base register value and an offset, adds or subtracts them, and then sequences the access and the base register update. The offset is either a zero-extended immediate or a second register value. A register offset first passes through a shifter that can shift left, shift right logically or arithmetically, rotate right, or rotate right by one through a carry bit.

Three control bits pick the addressing variant. In plain offset mode the computed address is used and the base is left alone. In pre-indexed mode the computed address is used and also written back to the base, and the writeback pulse comes before the access. In post-indexed mode the access goes to the unmodified base, and the updated value is written back only after memory has accepted the access. A word access to an address that is not a multiple of four is refused with a fault, and no access or writeback takes place.

The surrounding pipeline pulses `req_valid` with all operands while the block is idle. It answers `mem_req` with `mem_ready` and applies `wb_val` to the base register whenever `wb_en` is high.

Top module: `agu_wb_top`

## Requirements
- R1: Offset mode (ctl_pre=1, ctl_wb=0) accesses base+offset when ctl_up=1 and base−offset when ctl_up=0, and never raises wb_en.
- R2: Pre-indexed mode (ctl_pre=1, ctl_wb=1) accesses the same address as offset mode. It writes that address back in a single wb_en cycle that comes before the first mem_req cycle.
- R3: Post-indexed mode (ctl_pre=0, ctl_wb has no effect) accesses the unmodified base. It writes base±offset back in a single wb_en cycle that follows the cycle in which mem_ready was accepted.
- R4: With off_use_reg=0 the offset is off_imm zero-extended to the data width. With off_use_reg=1 it is the shifted off_reg.
- R5: shift_kind 0 shifts left, 1 shifts right logically, 2 shifts right arithmetically and 3 rotates right, each by shift_amt (0 to W−1). An amount of 0 leaves the value unchanged, and shift_cout then equals shift_cin. Otherwise shift_cout is the last bit shifted out.
- R6: shift_kind 4 moves the value right by one, puts shift_cin in the top bit and gives the old bit 0 on shift_cout, whatever shift_amt is. Kinds 5 to 7 pass the value unchanged with shift_cout equal to shift_cin.
- R7: During the access, mem_byte and mem_load show the ctl_byte and ctl_load values of the request.
- R8: A word request (ctl_byte=0) whose access address has a nonzero value in bits [1:0] produces no mem_req and no wb_en. It raises align_fault for the single done cycle.
- R9: mem_req stays high with a constant mem_addr until mem_ready is sampled high. done is high for exactly one cycle per request.
- R10: req_valid is ignored while busy is high. The operands of the request in flight are kept.
- R11: After reset the block is idle, with busy, mem_req, wb_en, done and align_fault low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a request (taken only when idle) |
| base_val | input | W | Base register value |
| off_imm | input | IMM_W | Immediate offset |
| off_reg | input | W | Register offset before shifting |
| off_use_reg | input | 1 | 1 selects the shifted register offset |
| shift_kind | input | 3 | Shift operator code |
| shift_amt | input | log2(W) | Shift amount |
| shift_cin | input | 1 | Carry into the shifter |
| ctl_pre | input | 1 | 1 indexes before the access, 0 after |
| ctl_up | input | 1 | 1 adds the offset, 0 subtracts it |
| ctl_wb | input | 1 | Writeback request when indexing before the access |
| ctl_byte | input | 1 | 1 byte access, 0 word access |
| ctl_load | input | 1 | 1 load, 0 store |
| mem_ready | input | 1 | Memory accepts the access |
| busy | output | 1 | A request is in flight |
| mem_req | output | 1 | Access request to memory |
| mem_addr | output | W | Access address |
| mem_byte | output | 1 | Access size |
| mem_load | output | 1 | Access direction |
| wb_en | output | 1 | Base register write enable |
| wb_val | output | W | Value for the base register |
| align_fault | output | 1 | Misaligned word access, shown in the done cycle |
| done | output | 1 | Request finished |
| shift_cout | output | 1 | Shifter carry out of the last request |

## Verification
A corrupted sequencer state shows up at the ports within the request that has it. A pre-indexed writeback that lands after the access, a post-indexed one that lands before mem_ready, or a second wb_en pulse all change the cycle order the bench records for each request. A wrong shift stage or carry selection shows up in mem_addr and shift_cout of that same request. The bench sweeps every shift code against every amount and compares against bit-by-bit arithmetic. A wrongly latched mode or fault flag shows up in the done cycle, either as a missing or extra align_fault or as a stray access.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2
    } addr_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_ADDR    = 3'd1,
        SQ_WB_PRE  = 3'd2,
        SQ_ACCESS  = 3'd3,
        SQ_WB_POST = 3'd4,
        SQ_DONE    = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic pre;
        logic up;
        logic wbit;
        logic is_byte;
        logic is_load;
    } acc_ctl_t;

    // Addressing variant from the indexing bits.
    function automatic addr_mode_e decode_mode(input logic pre, input logic wbit);
        if (!pre)
            return AM_POST;
        else if (wbit)
            return AM_PRE;
        else
            return AM_OFFSET;
    endfunction

endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
    import agu_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    val,
    input  shift_kind_e     kind,
    input  logic [SH_W-1:0] amt,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);
    logic [W-1:0]            rev_in;
    logic [W-1:0]            rev_out;
    logic [SH_W:0][W-1:0]    stg;
    logic                    fill;
    logic [SH_W-1:0]         amt_m1;
    logic [SH_W-1:0]         lsl_idx;

    // Left shifts run through the right shifter on a bit-reversed value.
    for (genvar gi = 0; gi < W; gi++) begin : g_rev
        assign rev_in[gi]  = val[W-1-gi];
        assign rev_out[gi] = stg[SH_W][W-1-gi];
    end

    assign fill   = (kind == SHK_ASR) ? val[W-1] : 1'b0;
    assign stg[0] = (kind == SHK_LSL) ? rev_in : val;

    // Logarithmic stages, stage s moves by 2**s.
    for (genvar gs = 0; gs < SH_W; gs++) begin : g_stage
        localparam int K = 1 << gs;
        logic [W-1:0] moved;
        assign moved = (kind == SHK_ROR) ? {stg[gs][K-1:0], stg[gs][W-1:K]}
                                         : {{K{fill}}, stg[gs][W-1:K]};
        assign stg[gs+1] = amt[gs] ? moved : stg[gs];
    end

    assign amt_m1  = amt - SH_W'(1);
    assign lsl_idx = SH_W'(W) - amt;

    always_comb begin
        res  = val;
        cout = cin;
        case (kind)
            SHK_LSL: begin
                res = rev_out;
                if (amt != '0) cout = val[lsl_idx];
            end
            SHK_LSR, SHK_ASR, SHK_ROR: begin
                res = stg[SH_W];
                if (amt != '0) cout = val[amt_m1];
            end
            SHK_RRX: begin
                res  = {cin, val[W-1:1]};
                cout = val[0];
            end
            default: begin
                res  = val;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 12
) (
    input  logic [W-1:0]     base,
    input  logic [IMM_W-1:0] imm,
    input  logic [W-1:0]     reg_off,
    input  logic             use_reg,
    input  logic             pre,
    input  logic             up,
    input  logic             wbit,
    input  logic             is_byte,
    output logic [W-1:0]     acc_addr,
    output logic [W-1:0]     upd_val,
    output logic             wb_need,
    output logic             wb_first,
    output logic             fault
);
    localparam int ALIGN_BITS = $clog2(W / 8);

    addr_mode_e   mode;
    logic [W-1:0] off;

    assign mode    = decode_mode(pre, wbit);
    assign off     = use_reg ? reg_off : {{(W-IMM_W){1'b0}}, imm};
    assign upd_val = up ? (base + off) : (base - off);

    always_comb begin
        case (mode)
            AM_POST: begin
                acc_addr = base;
                wb_need  = 1'b1;
                wb_first = 1'b0;
            end
            AM_PRE: begin
                acc_addr = upd_val;
                wb_need  = 1'b1;
                wb_first = 1'b1;
            end
            default: begin
                acc_addr = upd_val;
                wb_need  = 1'b0;
                wb_first = 1'b0;
            end
        endcase
    end

    assign fault = !is_byte && (acc_addr[ALIGN_BITS-1:0] != '0);

endmodule

// File: rtl/agu_seq.sv
module agu_seq
    import agu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         mem_ready,
    input  logic [W-1:0] calc_addr,
    input  logic [W-1:0] calc_upd,
    input  logic         calc_wb_need,
    input  logic         calc_wb_first,
    input  logic         calc_fault,
    input  logic         calc_cout,
    output logic         accept,
    output logic         busy,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    output logic         wb_en,
    output logic [W-1:0] wb_val,
    output logic         align_fault,
    output logic         done,
    output logic         shift_cout
);
    seq_state_e   state_q, state_d;
    logic [W-1:0] addr_q, upd_q;
    logic         need_q, first_q, fault_q, cout_q;

    assign accept = (state_q == SQ_IDLE) && start;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE:    if (start) state_d = SQ_ADDR;
            SQ_ADDR: begin
                if (calc_fault)
                    state_d = SQ_DONE;
                else if (calc_wb_need && calc_wb_first)
                    state_d = SQ_WB_PRE;
                else
                    state_d = SQ_ACCESS;
            end
            SQ_WB_PRE:  state_d = SQ_ACCESS;
            SQ_ACCESS: begin
                if (mem_ready)
                    state_d = (need_q && !first_q) ? SQ_WB_POST : SQ_DONE;
            end
            SQ_WB_POST: state_d = SQ_DONE;
            SQ_DONE:    state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            upd_q   <= '0;
            need_q  <= 1'b0;
            first_q <= 1'b0;
            fault_q <= 1'b0;
            cout_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_ADDR) begin
                addr_q  <= calc_addr;
                upd_q   <= calc_upd;
                need_q  <= calc_wb_need;
                first_q <= calc_wb_first;
                fault_q <= calc_fault;
                cout_q  <= calc_cout;
            end
        end
    end

    assign busy        = (state_q != SQ_IDLE);
    assign mem_req     = (state_q == SQ_ACCESS);
    assign mem_addr    = addr_q;
    assign wb_en       = (state_q == SQ_WB_PRE) || (state_q == SQ_WB_POST);
    assign wb_val      = upd_q;
    assign done        = (state_q == SQ_DONE);
    assign align_fault = done && fault_q;
    assign shift_cout  = cout_q;

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_wb_single_R9: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> !wb_en);

    assert_fault_no_access_R8: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> (!$past(mem_req) && !$past(wb_en)));

    assert_post_wb_after_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !first_q) |-> $past(mem_req && mem_ready));

endmodule

// File: rtl/agu_wb_top.sv
module agu_wb_top
    import agu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [W-1:0]         base_val,
    input  logic [IMM_W-1:0]     off_imm,
    input  logic [W-1:0]         off_reg,
    input  logic                 off_use_reg,
    input  logic [2:0]           shift_kind,
    input  logic [$clog2(W)-1:0] shift_amt,
    input  logic                 shift_cin,
    input  logic                 ctl_pre,
    input  logic                 ctl_up,
    input  logic                 ctl_wb,
    input  logic                 ctl_byte,
    input  logic                 ctl_load,
    input  logic                 mem_ready,
    output logic                 busy,
    output logic                 mem_req,
    output logic [W-1:0]         mem_addr,
    output logic                 mem_byte,
    output logic                 mem_load,
    output logic                 wb_en,
    output logic [W-1:0]         wb_val,
    output logic                 align_fault,
    output logic                 done,
    output logic                 shift_cout
);
    localparam int SH_W = $clog2(W);

    logic [W-1:0]     base_q, reg_q, shifted;
    logic [IMM_W-1:0] imm_q;
    logic             use_reg_q, cin_q;
    logic [2:0]       kind_q;
    logic [SH_W-1:0]  amt_q;
    acc_ctl_t         ctl_q;
    logic             accept, sh_cout;
    logic [W-1:0]     calc_addr, calc_upd;
    logic             calc_need, calc_first, calc_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            reg_q     <= '0;
            imm_q     <= '0;
            use_reg_q <= 1'b0;
            cin_q     <= 1'b0;
            kind_q    <= '0;
            amt_q     <= '0;
            ctl_q     <= '0;
        end else if (accept) begin
            base_q    <= base_val;
            reg_q     <= off_reg;
            imm_q     <= off_imm;
            use_reg_q <= off_use_reg;
            cin_q     <= shift_cin;
            kind_q    <= shift_kind;
            amt_q     <= shift_amt;
            ctl_q     <= '{pre: ctl_pre, up: ctl_up, wbit: ctl_wb,
                           is_byte: ctl_byte, is_load: ctl_load};
        end
    end

    agu_shifter #(.W(W), .SH_W(SH_W)) i_shift (
        .val  (reg_q),
        .kind (shift_kind_e'(kind_q)),
        .amt  (amt_q),
        .cin  (cin_q),
        .res  (shifted),
        .cout (sh_cout)
    );

    agu_addr_calc #(.W(W), .IMM_W(IMM_W)) i_calc (
        .base     (base_q),
        .imm      (imm_q),
        .reg_off  (shifted),
        .use_reg  (use_reg_q),
        .pre      (ctl_q.pre),
        .up       (ctl_q.up),
        .wbit     (ctl_q.wbit),
        .is_byte  (ctl_q.is_byte),
        .acc_addr (calc_addr),
        .upd_val  (calc_upd),
        .wb_need  (calc_need),
        .wb_first (calc_first),
        .fault    (calc_fault)
    );

    agu_seq #(.W(W)) i_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (req_valid),
        .mem_ready     (mem_ready),
        .calc_addr     (calc_addr),
        .calc_upd      (calc_upd),
        .calc_wb_need  (calc_need),
        .calc_wb_first (calc_first),
        .calc_fault    (calc_fault),
        .calc_cout     (sh_cout),
        .accept        (accept),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .wb_en         (wb_en),
        .wb_val        (wb_val),
        .align_fault   (align_fault),
        .done          (done),
        .shift_cout    (shift_cout)
    );

    assign mem_byte = ctl_q.is_byte;
    assign mem_load = ctl_q.is_load;

    assert_offset_no_wb_R1: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !(ctl_q.pre && !ctl_q.wbit));

    assert_pre_wb_then_access_R2: assert property (@(posedge clk) disable iff (rst)
        (wb_en && ctl_q.pre) |=> mem_req);

    assert_fault_word_only_R8: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> !ctl_q.is_byte);

    assert_busy_keeps_ops_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> ($stable(ctl_q) && $stable(base_q)));

endmodule

// File: tb/test_agu_wb_top.sv
`timescale 1ns/1ps
module test_agu_wb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [11:0] off_imm = '0;
    logic [31:0] off_reg = '0;
    logic        off_use_reg = 1'b0;
    logic [2:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic        shift_cin = 1'b0;
    logic        ctl_pre = 1'b0, ctl_up = 1'b0, ctl_wb = 1'b0, ctl_byte = 1'b0, ctl_load = 1'b0;
    logic        mem_ready = 1'b0;
    logic        busy, mem_req, mem_byte, mem_load, wb_en, align_fault, done, shift_cout;
    logic [31:0] mem_addr, wb_val;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    agu_wb_top i_agu_wb_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .base_val(base_val),
        .off_imm(off_imm), .off_reg(off_reg), .off_use_reg(off_use_reg),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .shift_cin(shift_cin),
        .ctl_pre(ctl_pre), .ctl_up(ctl_up), .ctl_wb(ctl_wb), .ctl_byte(ctl_byte),
        .ctl_load(ctl_load), .mem_ready(mem_ready), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_byte(mem_byte), .mem_load(mem_load), .wb_en(wb_en),
        .wb_val(wb_val), .align_fault(align_fault), .done(done), .shift_cout(shift_cout)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference shifter, one bit at a time (R5, R6).
    task automatic ref_shift(input logic [31:0] v, input logic [2:0] k, input int n, input logic ci,
                             output logic [31:0] r, output logic co);
        r = v; co = ci;
        case (k)
            3'd0: begin
                for (int i = 0; i < 32; i++) r[i] = (i >= n) ? v[i-n] : 1'b0;
                if (n != 0) co = v[32-n];
            end
            3'd1: begin
                for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : 1'b0;
                if (n != 0) co = v[n-1];
            end
            3'd2: begin
                for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : v[31];
                if (n != 0) co = v[n-1];
            end
            3'd3: begin
                for (int i = 0; i < 32; i++) r[i] = v[(i+n)%32];
                if (n != 0) co = v[n-1];
            end
            3'd4: begin
                for (int i = 0; i < 31; i++) r[i] = v[i+1];
                r[31] = ci;
                co = v[0];
            end
            default: begin r = v; co = ci; end
        endcase
    endtask

    task automatic run_txn(input logic [31:0] base, input logic [11:0] imm, input logic [31:0] rv,
                           input logic use_reg, input logic [2:0] kind, input int amt, input logic cin,
                           input logic p, input logic u, input logic w, input logic b, input logic l,
                           input int delay, input logic poke);
        logic [31:0] off, sh, upd, exp_addr;
        logic        exp_co, exp_wb, exp_fault;
        int          first_req, last_req, wb_cyc, wb_cnt, done_cnt, waited;
        logic [31:0] got_addr, got_wbv;
        logic        got_fault, got_co, got_b, got_l, addr_moved, busy1;
        string       otag;

        ref_shift(rv, kind, amt, cin, sh, exp_co);
        off       = use_reg ? sh : {20'd0, imm};
        upd       = u ? base + off : base - off;
        exp_addr  = p ? upd : base;
        exp_fault = !b && (exp_addr[1:0] != 2'b00);
        exp_wb    = !exp_fault && (!p || w);
        otag      = !use_reg ? "R4" : (kind >= 3'd4 ? "R6" : "R5");

        base_val = base; off_imm = imm; off_reg = rv; off_use_reg = use_reg;
        shift_kind = kind; shift_amt = 5'(amt); shift_cin = cin;
        ctl_pre = p; ctl_up = u; ctl_wb = w; ctl_byte = b; ctl_load = l;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        first_req = -1; last_req = -1; wb_cyc = -1; wb_cnt = 0; done_cnt = 0; waited = 0;
        got_addr = '0; got_wbv = '0; got_fault = 1'b0; got_co = 1'b0; got_b = 1'b0; got_l = 1'b0;
        addr_moved = 1'b0; busy1 = busy;
        for (int cyc = 1; cyc < 40; cyc++) begin
            if (mem_req) begin
                if (first_req < 0) begin
                    first_req = cyc; got_addr = mem_addr; got_b = mem_byte; got_l = mem_load;
                end else if (mem_addr != got_addr) addr_moved = 1'b1;
                last_req  = cyc;
                mem_ready = (waited >= delay);
                waited++;
                if (poke) begin
                    req_valid = 1'b1; base_val = ~base; ctl_pre = ~p; ctl_byte = ~b;
                end
            end else begin
                mem_ready = 1'b0;
                req_valid = 1'b0;
            end
            if (wb_en) begin wb_cnt++; wb_cyc = cyc; got_wbv = wb_val; end
            if (done) begin
                done_cnt++; got_fault = align_fault; got_co = shift_cout;
                req_valid = 1'b0;
                @(negedge clk);
                if (done) done_cnt++;
                break;
            end
            @(negedge clk);
        end
        mem_ready = 1'b0;
        req_valid = 1'b0;

        chk(busy1, "R9 busy after accept", 32'(busy1), 32'd1);
        chk(done_cnt == 1, "R9 single done pulse", 32'(done_cnt), 32'd1);
        chk(got_co == exp_co, {otag, " shift carry"}, 32'(got_co), 32'(exp_co));
        chk(got_fault == exp_fault, "R8 align fault", 32'(got_fault), 32'(exp_fault));
        if (exp_fault) begin
            chk(first_req < 0, "R8 no access on fault", 32'(first_req), 32'hFFFF_FFFF);
        end else begin
            chk(got_addr == exp_addr, {otag, p ? (w ? " R2" : " R1") : " R3", " address"}, got_addr, exp_addr);
            chk(!addr_moved && (last_req - first_req == delay), "R9 request held until ready",
                32'(last_req - first_req), 32'(delay));
            chk(got_b == b && got_l == l, "R7 size and direction", {30'd0, got_b, got_l}, {30'd0, b, l});
        end
        chk(wb_cnt == (exp_wb ? 1 : 0), p && !w ? "R1 no writeback" : "R2 R3 R8 writeback count",
            32'(wb_cnt), exp_wb ? 32'd1 : 32'd0);
        if (exp_wb) begin
            chk(got_wbv == upd, p ? "R2 writeback value" : "R3 writeback value", got_wbv, upd);
            if (p) chk(wb_cyc < first_req, "R2 writeback before access", 32'(wb_cyc), 32'(first_req));
            else   chk(wb_cyc == last_req + 1, "R3 writeback after ready", 32'(wb_cyc), 32'(last_req + 1));
        end
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: idle after reset
        chk(!busy && !mem_req && !wb_en && !done && !align_fault, "R11 reset state",
            {27'd0, busy, mem_req, wb_en, done, align_fault}, 32'd0);

        // R5, R6: every shift code against every amount, offset mode, byte access
        for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 32; n++) begin
                run_txn(32'h0001_0000, 12'h000, (n % 2 == 1) ? 32'hF0A5_3C81 : 32'h4B2D_9E16,
                        1'b1, 3'(k), n, 1'(k ^ n), 1'b1, 1'(n >> 1), 1'b0, 1'b1, 1'(n),
                        n % 3, 1'b0);
            end
        end

        // R1, R2, R3, R4, R7, R8: all control combinations with immediate offsets
        for (int c = 0; c < 32; c++) begin
            for (int bsel = 0; bsel < 3; bsel++) begin
                for (int isel = 0; isel < 2; isel++) begin
                    run_txn(bsel == 0 ? 32'h0000_1000 : (bsel == 1 ? 32'h0000_1002 : 32'hFFFF_FFFC),
                            isel == 0 ? 12'h004 : 12'hFF3, 32'h0, 1'b0, 3'd0, 0, 1'b0,
                            1'(c >> 4), 1'(c >> 3), 1'(c >> 2), 1'(c >> 1), 1'(c),
                            (c + bsel) % 4, 1'b0);
                end
            end
        end

        // R2, R3, R4: scaled register offset in indexing modes, word access
        for (int m = 0; m < 4; m++) begin
            run_txn(32'h2000_0040, 12'h0, 32'h0000_0013, 1'b1, 3'd0, 2, 1'b0,
                    1'(m >> 1), 1'(m), 1'b1, 1'b0, 1'b1, m, 1'b0);
        end

        // R10: requests during the access are ignored
        run_txn(32'h0000_3000, 12'h010, 32'h0, 1'b0, 3'd0, 0, 1'b0,
                1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3, 1'b1);
        chk(!busy, "R10 idle after ignored request", 32'(busy), 32'd0);
        run_txn(32'h0000_3000, 12'h010, 32'h0, 1'b0, 3'd0, 0, 1'b0,
                1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule